// File: doc/BRIEF.md
# Power-fail chip-enable gate

This block sits between the address decoder and a battery-backed memory. It passes the active-low chip enable through to the memory while the supply is valid. When a power fault appears, it stops any new memory access from starting. A fault is either a drop of the supply-good indication or an asserted supervisor reset. An access that is already under way keeps its enable for a bounded number of clock cycles, so that the cycle can complete cleanly instead of being cut short.

The block also produces two registered status flags. The first is an active-low low-line flag that tracks the supply-good indication with no hold-off. The second is a battery-on flag that follows the supply-versus-battery comparison, with hysteresis between its set and clear conditions. When the supply is below the reset threshold and also below the battery, the block is in backup mode. Backup mode removes the enable at once and grants no grace window.

All outputs are registered and update on the rising clock edge that samples the inputs. The grace window length is the parameter `GRACE_CYC` in clock cycles. At 100 MHz, the default of 1500 cycles gives 15 µs.

Top module: `pfg_ce_gate`

## Requirements
- R1: While `supply_ok` is 1 and `sup_rst` is 0 at a rising edge, `ce_out_n` after that edge equals the `ce_in_n` sampled at that edge.
- R2: When a fault is sampled and no access is in progress, `ce_out_n` is 1 after that edge whatever `ce_in_n` is. A fault is `supply_ok`=0 or `sup_rst`=1. No access is in progress when `ce_out_n` or `ce_in_n` is 1 at that edge.
- R3: An access is in progress when `ce_out_n` and `ce_in_n` are both 0 at the first faulted edge. In that case `ce_out_n` stays 0 until an edge samples `ce_in_n`=1, or for at most `GRACE_CYC` edges after the fault edge, whichever comes first. It then goes to 1.
- R4: Once `ce_out_n` has been forced to 1 during a fault, it stays 1 until an edge samples the fault as cleared, even if `ce_in_n` goes low again.
- R5: `low_line_n` after each edge equals the `supply_ok` sampled at that edge.
- R6: `batt_on` is set by an edge that samples `supply_ok`=0 with `batt_above`=1. It is cleared by an edge that samples `supply_ok`=1 with `batt_above`=0. Otherwise it holds its value.
- R7: In backup mode (`supply_ok`=0 and `batt_above`=1 at an edge), `ce_out_n` is 1 after that edge, even during a grace window.
- R8: An edge that samples `rst`=1 sets `ce_out_n`=1, `low_line_n`=0 and `batt_on`=0.
- R9: `sup_rst`=1 with `supply_ok`=1 is a fault in the same way as a supply drop, including the R3 grace window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above reset threshold |
| batt_above | input | 1 | Battery voltage above supply |
| sup_rst | input | 1 | Supervisor reset asserted (active high) |
| ce_in_n | input | 1 | Chip enable from address decode, active low |
| ce_out_n | output | 1 | Gated chip enable to memory, active low |
| low_line_n | output | 1 | Low-supply flag, active low |
| batt_on | output | 1 | Backup battery selected |

## Verification
Every output has one register between the inputs and the port, so each result is due on the first rising edge after the stimulus. The bench drives inputs on the falling edge and compares all three outputs at the next falling edge, once the single register stage has settled. The grace timeout is due `GRACE_CYC` edges after the edge that first sampled the fault. The bench reference advances its own cycle counter one edge at a time, so the exact release edge is compared rather than a window.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [1:0] {
        GATE_PASS = 2'd0,
        GATE_HOLD = 2'd1,
        GATE_SHUT = 2'd2
    } gate_st_e;

    typedef struct packed {
        logic supply_ok;
        logic batt_above;
        logic sup_rst;
        logic ce_in_n;
    } pwr_in_t;

    typedef struct packed {
        logic fault;
        logic backup;
    } fault_t;

    function automatic fault_t classify(input pwr_in_t i);
        fault_t f;
        f.fault  = !i.supply_ok || i.sup_rst;
        f.backup = !i.supply_ok && i.batt_above;
        return f;
    endfunction

    function automatic logic batt_next(input logic cur, input pwr_in_t i);
        if (!i.supply_ok && i.batt_above)
            return 1'b1;
        else if (i.supply_ok && !i.batt_above)
            return 1'b0;
        else
            return cur;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pfg_status_flags.sv
module pfg_status_flags
    import pfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pwr_in_t pin,
    output logic    low_line_n,
    output logic    batt_on
);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_line_n <= 1'b0;
            batt_on    <= 1'b0;
        end else begin
            low_line_n <= pin.supply_ok;
            batt_on    <= batt_next(batt_on, pin);
        end
    end

endmodule

// File: rtl/pfg_grace_timer.sv
module pfg_grace_timer
    import pfg_pkg::*;
#(
    parameter int unsigned GRACE_CYC = 1500
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);

    localparam int unsigned CW = cnt_width(GRACE_CYC);
    localparam logic [CW-1:0] LAST = CW'(GRACE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (run && cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == LAST);

endmodule

// File: rtl/pfg_gate_fsm.sv
module pfg_gate_fsm
    import pfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pwr_in_t pin,
    input  fault_t  flt,
    input  logic    expired,
    output logic    ce_out_n,
    output logic    tmr_clr,
    output logic    tmr_run
);

    gate_st_e st_q, st_d;
    logic     ce_d;

    always_comb begin
        st_d    = st_q;
        ce_d    = 1'b1;
        tmr_clr = 1'b0;
        tmr_run = 1'b0;
        unique case (st_q)
            GATE_PASS: begin
                if (!flt.fault) begin
                    ce_d = pin.ce_in_n;
                end else if (!ce_out_n && !pin.ce_in_n && !flt.backup) begin
                    st_d    = GATE_HOLD;
                    ce_d    = 1'b0;
                    tmr_clr = 1'b1;
                end else begin
                    st_d = GATE_SHUT;
                end
            end
            GATE_HOLD: begin
                if (!flt.fault) begin
                    st_d = GATE_PASS;
                    ce_d = pin.ce_in_n;
                end else if (pin.ce_in_n || expired || flt.backup) begin
                    st_d = GATE_SHUT;
                end else begin
                    ce_d    = 1'b0;
                    tmr_run = 1'b1;
                end
            end
            default: begin
                if (!flt.fault) begin
                    st_d = GATE_PASS;
                    ce_d = pin.ce_in_n;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= GATE_SHUT;
            ce_out_n <= 1'b1;
        end else begin
            st_q     <= st_d;
            ce_out_n <= ce_d;
        end
    end

endmodule

// File: rtl/pfg_ce_gate.sv
module pfg_ce_gate
    import pfg_pkg::*;
#(
    parameter int unsigned GRACE_CYC = 1500
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic batt_above,
    input  logic sup_rst,
    input  logic ce_in_n,
    output logic ce_out_n,
    output logic low_line_n,
    output logic batt_on
);

    pwr_in_t pin;
    fault_t  flt;
    logic    tmr_clr, tmr_run, expired;

    always_comb begin
        pin.supply_ok  = supply_ok;
        pin.batt_above = batt_above;
        pin.sup_rst    = sup_rst;
        pin.ce_in_n    = ce_in_n;
        flt            = classify(pin);
    end

    pfg_status_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .pin        (pin),
        .low_line_n (low_line_n),
        .batt_on    (batt_on)
    );

    pfg_grace_timer #(.GRACE_CYC(GRACE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .expired (expired)
    );

    pfg_gate_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pin      (pin),
        .flt      (flt),
        .expired  (expired),
        .ce_out_n (ce_out_n),
        .tmr_clr  (tmr_clr),
        .tmr_run  (tmr_run)
    );

endmodule

// File: rtl/pfg_ce_gate_chk.sv
module pfg_ce_gate_chk #(
    parameter int unsigned GRACE_CYC = 1500
) (
    input logic clk,
    input logic rst,
    input logic supply_ok,
    input logic batt_above,
    input logic sup_rst,
    input logic ce_in_n,
    input logic ce_out_n,
    input logic low_line_n,
    input logic batt_on
);

    logic        fault;
    int unsigned low_run;

    assign fault = !supply_ok || sup_rst;

    always_ff @(posedge clk) begin
        if (rst)
            low_run <= 0;
        else if (fault && !ce_out_n)
            low_run <= low_run + 1;
        else
            low_run <= 0;
    end

    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        !fault |=> ce_out_n == $past(ce_in_n));

    // R2
    blocked_start_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && ce_in_n) |=> ce_out_n);

    // R3
    grace_bound_chk: assert property (@(posedge clk) disable iff (rst)
        low_run <= GRACE_CYC + 1);

    // R4
    stay_shut_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && ce_out_n) |=> ce_out_n);

    // R5
    low_line_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> low_line_n == $past(supply_ok));

    // R6
    batt_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!supply_ok && batt_above) |=> batt_on);

    // R6
    batt_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && !batt_above) |=> !batt_on);

    // R7
    backup_shut_chk: assert property (@(posedge clk) disable iff (rst)
        (!supply_ok && batt_above) |=> ce_out_n);

    // R8
    reset_safe_chk: assert property (@(posedge clk)
        rst |=> (ce_out_n && !low_line_n && !batt_on));

endmodule

bind pfg_ce_gate pfg_ce_gate_chk #(.GRACE_CYC(GRACE_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .supply_ok  (supply_ok),
    .batt_above (batt_above),
    .sup_rst    (sup_rst),
    .ce_in_n    (ce_in_n),
    .ce_out_n   (ce_out_n),
    .low_line_n (low_line_n),
    .batt_on    (batt_on)
);

// File: tb/pfg_ce_gate_bench.sv
module pfg_ce_gate_bench;

    localparam int unsigned G = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0, batt_above = 1'b0, sup_rst = 1'b0, ce_in_n = 1'b1;
    logic ce_out_n, low_line_n, batt_on;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    // reference state: 0 pass, 1 hold, 2 shut
    int   m_st  = 2;
    int   m_cnt = 0;
    logic m_ce  = 1'b1;
    logic m_ll  = 1'b0;
    logic m_bo  = 1'b0;
    string ce_tag = "R8";

    always #5 clk = ~clk;

    pfg_ce_gate #(.GRACE_CYC(G)) u_pfg_ce_gate (
        .clk        (clk),
        .rst        (rst),
        .supply_ok  (supply_ok),
        .batt_above (batt_above),
        .sup_rst    (sup_rst),
        .ce_in_n    (ce_in_n),
        .ce_out_n   (ce_out_n),
        .low_line_n (low_line_n),
        .batt_on    (batt_on)
    );

    function automatic logic exp_batt(input logic cur, input logic s, input logic b);
        if (!s && b) return 1'b1;
        if (s && !b) return 1'b0;
        return cur;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic s, input logic b, input logic r, input logic c);
        logic f, bk, nce;
        int   nst;
        f   = !s || r;
        bk  = !s && b;
        nst = m_st;
        nce = 1'b1;
        if (m_st == 0) begin
            if (!f) begin
                nce = c; ce_tag = "R1";
            end else if (!m_ce && !c && !bk) begin
                nst = 1; nce = 1'b0; m_cnt = 0; ce_tag = "R3";
            end else begin
                nst = 2; ce_tag = bk ? "R7" : "R2";
            end
        end else if (m_st == 1) begin
            if (!f) begin
                nst = 0; nce = c; ce_tag = "R1";
            end else if (c || m_cnt == G - 1 || bk) begin
                nst = 2; ce_tag = bk ? "R7" : "R3";
            end else begin
                nce = 1'b0; m_cnt++; ce_tag = "R3";
            end
        end else begin
            if (!f) begin
                nst = 0; nce = c; ce_tag = "R1";
            end else begin
                ce_tag = "R4";
            end
        end
        if (f && s && r) ce_tag = "R9";
        m_st = nst;
        m_ce = nce;
        m_ll = s;
        m_bo = exp_batt(m_bo, s, b);
    endtask

    task automatic cyc(input logic s, input logic b, input logic r, input logic c);
        supply_ok = s; batt_above = b; sup_rst = r; ce_in_n = c;
        model_step(s, b, r, c);
        @(posedge clk);
        @(negedge clk);
        check(ce_tag, ce_out_n, m_ce);
        check("R5", low_line_n, m_ll);
        check("R6", batt_on, m_bo);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        supply_ok = 1'b1; batt_above = 1'b1; ce_in_n = 1'b0; sup_rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R8", ce_out_n, 1'b1);
        check("R8", low_line_n, 1'b0);
        check("R8", batt_on, 1'b0);
        m_st = 2; m_cnt = 0; m_ce = 1'b1; m_ll = 1'b0; m_bo = 1'b0;
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        // R1 pass-through under toggling enable
        cyc(1, 0, 0, 1); cyc(1, 0, 0, 0); cyc(1, 0, 0, 1); cyc(1, 0, 0, 0);
        // R3 grace window runs out with enable held low
        for (int i = 0; i < G + 3; i++) cyc(0, 0, 0, 0);
        // R4 enable toggles while still faulted
        cyc(0, 0, 0, 1); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
        cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
        // R3 access ends early
        cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);
        // R2 fault with no access
        cyc(1, 0, 0, 1); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
        // R7 and R6 backup mode cuts an access at once
        cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
        cyc(0, 0, 0, 0); cyc(1, 1, 0, 0); cyc(1, 0, 0, 0);
        // R7 backup arrives during grace
        cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 1, 0, 0); cyc(1, 0, 0, 0);
        // R9 supervisor reset opens a grace window
        cyc(1, 0, 0, 0); cyc(1, 0, 1, 0); cyc(1, 0, 1, 0); cyc(1, 0, 1, 1);
        cyc(1, 0, 1, 0); cyc(1, 0, 0, 0);
        // R8 reset in mid-run
        do_reset();
        // mixed random traffic
        begin
            logic s = 1'b1, b = 1'b0, r = 1'b0, c = 1'b1;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom % 25 == 0) s = ~s;
                if ($urandom % 30 == 0) b = ~b;
                if ($urandom % 60 == 0) r = ~r;
                if ($urandom % 4 == 0) c = ~c;
                cyc(s, b, r, c);
            end
        end
        finish_run();
    end

endmodule